// File: doc/BRIEF.md
# Bulk Transfer Path Acquisition Controller

This controller sits in each core's network interface and obtains an end-to-end data path before a bulk block moves. A request names a destination and a block length. The controller sends a setup packet on the control network and then waits for the network's answer. An acknowledge means the path is held. The block then streams out under a valid/ready handshake, with no buffering or per-hop handling on the way. After the final word, a teardown packet goes out on the same route to release it.

If the control network answers with a drop notice, the controller does not wait for the blocking traffic to clear. In the very next cycle it reissues setup on the other route variant, which uses the path multiplicity of the network. The number of retries has a cap. A response timer ends a wait that never receives an answer. A request marked short skips path acquisition and goes out as a single control packet.

Top module: `bulk_path_ctrl`

## Requirements
- R1: No stream word is offered until an acknowledge has arrived for the current setup. Every bulk request first emits a setup packet (`ctl_kind` 2'b00) that carries the request's destination.
- R2: The first setup of a request uses variant 0. A drop notice received while waiting makes the next cycle present a new setup on the other variant (0 and 1 alternate).
- R3: At most MAX_RETRY retries follow the first setup. A drop on the final permitted attempt ends the request with a one-cycle `fail` and `fail_cause` = 0.
- R4: A wait of TIMEOUT_CYC cycles with no response ends the request with a one-cycle `fail` and `fail_cause` = 1. A response that arrives within the window is accepted.
- R5: After an acknowledge, exactly the programmed number of words is offered. `str_valid` stays high until each word is accepted, and `str_last` marks only the final word.
- R6: A length field of 0 requests the largest block, 2^LEN_W words.
- R7: Once the last word is accepted, a teardown packet (`ctl_kind` 2'b01) is presented. It carries the destination and variant of the acknowledged path and is followed by a one-cycle `done`.
- R8: A short request emits one control packet (`ctl_kind` 2'b10) to its destination, with no setup and no stream, and then pulses `done`.
- R9: While `ctl_valid` is high and `ctl_ready` is low, the packet kind, destination and variant hold steady.
- R10: `req_ready` is high only while idle. Requests made while busy are ignored. Responses are ignored outside the waiting phase.
- R11: When acknowledge and drop arrive in the same cycle, the acknowledge wins.
- R12: After reset, `req_ready` is 1 and `ctl_valid`, `str_valid`, `done` and `fail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Controller idle, accepts a request |
| req_short | input | 1 | Request is a short control-packet message |
| req_dest | input | DEST_W | Destination core |
| req_len | input | LEN_W | Block length in words, 0 means 2^LEN_W |
| ctl_valid | output | 1 | Control packet presented |
| ctl_ready | input | 1 | Control network takes the packet |
| ctl_kind | output | 2 | 00 setup, 01 teardown, 10 short message |
| ctl_dest | output | DEST_W | Destination in the control packet |
| ctl_variant | output | VAR_W | Route variant in the control packet |
| rsp_ack | input | 1 | Path acknowledged (pulse) |
| rsp_drop | input | 1 | Setup dropped on contention (pulse) |
| str_valid | output | 1 | Stream word offered |
| str_ready | input | 1 | Stream word taken |
| str_last | output | 1 | Offered word is the final one |
| done | output | 1 | Request finished (pulse) |
| fail | output | 1 | Request abandoned (pulse) |
| fail_cause | output | 1 | 0 retries exhausted, 1 response timeout |

## Verification
The bench sweeps every block length of a small configuration, including the zero-length field. A design with an off-by-one length counter would send one word too many or too few, or would raise `str_last` on the wrong word. It drives every drop count from none up to one past the cap, which exposes a controller that keeps retrying one route or allows one retry too many or too few. It also times a lost acknowledge to the exact cycle, so a timer that fires early or late shows up. It sends acknowledge and drop together, which catches a controller that gives priority to the drop. It pulses responses and new requests while the controller is busy and stalls both handshakes, which catches a controller that changes route or destination when it should not.

// File: rtl/bpc_pkg.sv
// Shared types of the bulk path controller.
// Assumes: nothing beyond a standard SystemVerilog compiler.
package bpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEND_SETUP, ST_WAIT_RESP, ST_STREAM,
        ST_SEND_TEARDOWN, ST_SEND_SHORT, ST_DONE, ST_ERROR
    } ctrl_state_t;

    typedef enum logic [1:0] {
        PKT_SETUP    = 2'b00,
        PKT_TEARDOWN = 2'b01,
        PKT_SHORT    = 2'b10
    } pkt_kind_t;

endpackage

// File: rtl/bpc_route_sel.sv
// Route variant selection and retry bookkeeping.
// Holds the variant for the current setup and counts the retries already used.
// Assumes: start and step are never high together; step is only raised when
// exhausted is low.
module bpc_route_sel #(
    parameter int NUM_VARIANTS = 2,
    parameter int MAX_RETRY    = 3,
    localparam int VAR_W = (NUM_VARIANTS > 1) ? $clog2(NUM_VARIANTS) : 1,
    localparam int RTY_W = $clog2(MAX_RETRY + 1) > 0 ? $clog2(MAX_RETRY + 1) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    output logic [VAR_W-1:0] variant,
    output logic             exhausted
);

    logic [RTY_W-1:0] used_q;

    // Retry counter: cleared per request, advanced per retry.
    always_ff @(posedge clk) begin
        if (!rst_n || start) used_q <= '0;
        else if (step)       used_q <= used_q + 1'b1;
    end

    assign exhausted = (used_q == RTY_W'(MAX_RETRY));

    generate
        if (NUM_VARIANTS == 2) begin : g_toggle
            // Two variants: flip between them on each retry.
            always_ff @(posedge clk) begin
                if (!rst_n || start) variant <= '0;
                else if (step)       variant <= ~variant;
            end
        end else if (NUM_VARIANTS > 2) begin : g_rotate
            // Several variants: rotate through them in order.
            always_ff @(posedge clk) begin
                if (!rst_n || start) variant <= '0;
                else if (step)
                    variant <= (variant == VAR_W'(NUM_VARIANTS - 1)) ? '0 : variant + 1'b1;
            end
        end else begin : g_single
            assign variant = '0;
        end
    endgenerate

    AST_STEP_NOT_EXHAUSTED: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !exhausted); // R3

    generate
        if (NUM_VARIANTS > 1) begin : g_chk_var
            AST_RETRY_NEW_VARIANT: assert property (@(posedge clk) disable iff (!rst_n)
                step && !start |=> variant != $past(variant)); // R2
        end
    endgenerate

endmodule

// File: rtl/bpc_resp_timer.sv
// Response wait timer. Counts the cycles spent waiting and flags the final one.
// Assumes: run stays high for the whole wait and low at all other times.
module bpc_resp_timer #(
    parameter int TIMEOUT_CYC = 256,
    localparam int TM_W = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last_cycle
);

    logic [TM_W-1:0] cnt_q;

    // Count while waiting, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign last_cycle = run && (cnt_q == TM_W'(TIMEOUT_CYC - 1));

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q < TM_W'(TIMEOUT_CYC)); // R4

endmodule

// File: rtl/bpc_len_count.sv
// Block length counter. It latches the programmed length and counts accepted
// words. The length wraps, so a zero field gives 2^LEN_W words.
// Assumes: load occurs only while no stream is in progress.
module bpc_len_count #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             advance,
    output logic             is_last
);

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;

    // Latch the length at request acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)    len_q <= '0;
        else if (load) len_q <= len;
    end

    // Count words taken by the sink.
    always_ff @(posedge clk) begin
        if (!rst_n || load) cnt_q <= '0;
        else if (advance)   cnt_q <= cnt_q + 1'b1;
    end

    assign is_last = (cnt_q == len_q - 1'b1);

endmodule

// File: rtl/bulk_path_ctrl.sv
// Path acquisition and retry controller for bulk transfers.
// Sequence: setup, wait for ack or drop, retry on the alternate variant after
// a drop, stream the block, teardown. Short requests become a single control
// packet.
// Assumes: rsp_ack and rsp_drop are single-cycle pulses; the word payload
// travels next to the str_* handshake outside this block.
module bulk_path_ctrl
    import bpc_pkg::*;
#(
    parameter int DEST_W       = 6,
    parameter int LEN_W        = 12,
    parameter int NUM_VARIANTS = 2,
    parameter int MAX_RETRY    = 3,
    parameter int TIMEOUT_CYC  = 256,
    localparam int VAR_W = (NUM_VARIANTS > 1) ? $clog2(NUM_VARIANTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_short,
    input  logic [DEST_W-1:0] req_dest,
    input  logic [LEN_W-1:0]  req_len,
    output logic              ctl_valid,
    input  logic              ctl_ready,
    output logic [1:0]        ctl_kind,
    output logic [DEST_W-1:0] ctl_dest,
    output logic [VAR_W-1:0]  ctl_variant,
    input  logic              rsp_ack,
    input  logic              rsp_drop,
    output logic              str_valid,
    input  logic              str_ready,
    output logic              str_last,
    output logic              done,
    output logic              fail,
    output logic              fail_cause
);

    ctrl_state_t       state_q, state_d;
    logic [DEST_W-1:0] dest_q;
    logic              cause_q, cause_d;
    logic              accept, retry, exhausted, tmo_last, word_last;
    logic [VAR_W-1:0]  variant;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign retry  = (state_q == ST_WAIT_RESP) && !rsp_ack && rsp_drop && !exhausted;

    bpc_route_sel #(.NUM_VARIANTS(NUM_VARIANTS), .MAX_RETRY(MAX_RETRY)) u_route (
        .clk(clk), .rst_n(rst_n), .start(accept), .step(retry),
        .variant(variant), .exhausted(exhausted)
    );

    bpc_resp_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_WAIT_RESP),
        .last_cycle(tmo_last)
    );

    bpc_len_count #(.LEN_W(LEN_W)) u_len (
        .clk(clk), .rst_n(rst_n), .load(accept), .len(req_len),
        .advance(str_valid && str_ready), .is_last(word_last)
    );

    // Next-state logic for the request sequence.
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            ST_IDLE:
                if (req_valid) state_d = req_short ? ST_SEND_SHORT : ST_SEND_SETUP;
            ST_SEND_SETUP:
                if (ctl_ready) state_d = ST_WAIT_RESP;
            ST_WAIT_RESP:
                if (rsp_ack)                      state_d = ST_STREAM;
                else if (rsp_drop && !exhausted)  state_d = ST_SEND_SETUP;
                else if (rsp_drop) begin
                    state_d = ST_ERROR;
                    cause_d = 1'b0;
                end else if (tmo_last) begin
                    state_d = ST_ERROR;
                    cause_d = 1'b1;
                end
            ST_STREAM:
                if (str_ready && word_last) state_d = ST_SEND_TEARDOWN;
            ST_SEND_TEARDOWN, ST_SEND_SHORT:
                if (ctl_ready) state_d = ST_DONE;
            ST_DONE, ST_ERROR:
                state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    // State, failure cause and latched destination registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= 1'b0;
            dest_q  <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            if (accept) dest_q <= req_dest;
        end
    end

    // Port outputs decoded from the current state.
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        ctl_valid  = (state_q == ST_SEND_SETUP) || (state_q == ST_SEND_TEARDOWN) ||
                     (state_q == ST_SEND_SHORT);
        ctl_kind   = (state_q == ST_SEND_TEARDOWN) ? PKT_TEARDOWN :
                     (state_q == ST_SEND_SHORT)    ? PKT_SHORT : PKT_SETUP;
        ctl_dest   = dest_q;
        ctl_variant = variant;
        str_valid  = (state_q == ST_STREAM);
        str_last   = str_valid && word_last;
        done       = (state_q == ST_DONE);
        fail       = (state_q == ST_ERROR);
        fail_cause = cause_q;
    end

    AST_NO_DATA_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(str_valid) |-> $past(rsp_ack)); // R1

    AST_STOP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        str_valid && str_ready && str_last |=> !str_valid); // R5

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_valid && !ctl_ready |=> ctl_valid && $stable(ctl_kind) &&
        $stable(ctl_dest) && $stable(ctl_variant)); // R9

    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        str_valid && !str_ready |=> str_valid && $stable(str_last)); // R5

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail)); // R7

    AST_TEARDOWN_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_valid) && ctl_kind == PKT_TEARDOWN |-> $past(str_last && str_ready)); // R7

endmodule

// File: tb/bulk_path_ctrl_tb.sv
module bulk_path_ctrl_tb;

    localparam int DW = 4;
    localparam int LW = 4;
    localparam int MR = 3;
    localparam int TO = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_short = 0, ctl_ready = 0, rsp_ack = 0, rsp_drop = 0, str_ready = 0;
    logic [DW-1:0] req_dest = '0;
    logic [LW-1:0] req_len = '0;
    logic req_ready, ctl_valid, str_valid, str_last, done, fail, fail_cause;
    logic [1:0] ctl_kind;
    logic [DW-1:0] ctl_dest;
    logic [0:0] ctl_variant;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    bulk_path_ctrl #(.DEST_W(DW), .LEN_W(LW), .NUM_VARIANTS(2), .MAX_RETRY(MR),
                     .TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_short(req_short), .req_dest(req_dest), .req_len(req_len),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_kind(ctl_kind),
        .ctl_dest(ctl_dest), .ctl_variant(ctl_variant), .rsp_ack(rsp_ack),
        .rsp_drop(rsp_drop), .str_valid(str_valid), .str_ready(str_ready),
        .str_last(str_last), .done(done), .fail(fail), .fail_cause(fail_cause)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // One request. drops: drop notices before the final answer.
    // lose: no answer after the drops. both: ack and drop together.
    task automatic run_xfer(input logic [DW-1:0] dst, input logic [LW-1:0] len,
                            input bit shrt, input int drops, input bit lose,
                            input bit stall, input bit both);
        int n;
        int i;
        int k;
        chk("R10 idle ready", req_ready, 1);
        req_valid = 1; req_dest = dst; req_len = len; req_short = shrt;
        cyc();
        req_dest = ~dst; req_len = len + 4'd3; req_short = ~shrt;  // busy, to be ignored
        chk("R10 busy not ready", req_ready, 0);
        if (shrt) begin
            chk("R8 ctl valid", ctl_valid, 1);
            chk("R8 kind short", ctl_kind, 2);
            chk("R8 dest", ctl_dest, dst);
            if (stall) begin
                cyc();
                chk("R9 short held", ctl_valid, 1);
                chk("R9 kind held", ctl_kind, 2);
            end
            ctl_ready = 1; cyc(); ctl_ready = 0;
            chk("R8 done", done, 1);
            chk("R8 no stream", str_valid, 0);
            req_valid = 0;
            cyc();
            return;
        end
        for (int a = 0; a <= MR; a++) begin
            chk("R1 setup valid", ctl_valid, 1);
            chk("R1 setup kind", ctl_kind, 0);
            chk("R1 setup dest", ctl_dest, dst);
            chk("R2 variant", ctl_variant, a % 2);
            if (stall) begin
                rsp_drop = 1;  // ignored outside the wait
                cyc(); rsp_drop = 0;
                chk("R9 setup held", ctl_valid, 1);
                chk("R10 early drop ignored", ctl_variant, a % 2);
            end
            ctl_ready = 1; cyc(); ctl_ready = 0;
            chk("R1 no data in wait", str_valid, 0);
            chk("R1 ctl idle in wait", ctl_valid, 0);
            if (a < drops) begin
                for (int w = 0; w < a; w++) cyc();
                rsp_drop = 1; cyc(); rsp_drop = 0;
                if (a == MR) begin
                    chk("R3 fail on cap", fail, 1);
                    chk("R3 cause retries", fail_cause, 0);
                    req_valid = 0;
                    cyc();
                    chk("R3 back idle", req_ready, 1);
                    return;
                end
            end else if (lose) begin
                for (int w = 0; w < TO - 1; w++) cyc();
                chk("R4 not yet failed", fail, 0);
                cyc();
                chk("R4 fail timeout", fail, 1);
                chk("R4 cause timeout", fail_cause, 1);
                req_valid = 0;
                cyc();
                return;
            end else begin
                for (int w = 0; w < TO - 1; w++) if (w < (a + 2) % TO) cyc();
                rsp_ack = 1; rsp_drop = both; cyc(); rsp_ack = 0; rsp_drop = 0;
                if (both) chk("R11 ack wins", str_valid, 1);
                break;
            end
        end
        n = (len == 0) ? (1 << LW) : len;
        i = 0; k = 0;
        while (i < n) begin
            chk("R5 valid", str_valid, 1);
            chk("R5 last", str_last, (i == n - 1) ? 1 : 0);
            str_ready = !(stall && (k % 2 == 0));
            rsp_drop = (k == 1);  // ignored while streaming
            if (str_ready) i++;
            k++;
            cyc();
        end
        str_ready = 0; rsp_drop = 0;
        chk(len == 0 ? "R6 stop" : "R5 stop", str_valid, 0);
        chk("R7 teardown valid", ctl_valid, 1);
        chk("R7 teardown kind", ctl_kind, 1);
        chk("R7 teardown dest", ctl_dest, dst);
        chk("R7 teardown variant", ctl_variant, drops % 2);
        req_valid = 0;
        if (stall) begin
            cyc();
            chk("R9 teardown held", ctl_kind, 1);
        end
        ctl_ready = 1; cyc(); ctl_ready = 0;
        chk("R7 done", done, 1);
        chk("R7 no fail", fail, 0);
        cyc();
        chk("R7 done one cycle", done, 0);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        chk("R12 reset ready", req_ready, 1);
        chk("R12 reset ctl", ctl_valid, 0);
        chk("R12 reset stream", str_valid, 0);
        chk("R12 reset done", done, 0);
        chk("R12 reset fail", fail, 0);
        for (int l = 0; l < (1 << LW); l++)
            run_xfer(DW'(l), LW'(l), 0, 0, 0, l % 3 == 0, 0);
        for (int d = 1; d <= MR; d++)
            for (int s = 0; s < 2; s++)
                run_xfer(DW'(d + 5), LW'(d + 1), 0, d, 0, s[0], 0);
        run_xfer(4'd9, 4'd2, 0, MR + 1, 0, 0, 0);
        run_xfer(4'd9, 4'd2, 0, MR + 1, 0, 1, 0);
        run_xfer(4'd3, 4'd4, 0, 0, 1, 0, 0);
        run_xfer(4'd3, 4'd4, 0, 2, 1, 1, 0);
        run_xfer(4'd7, 4'd1, 1, 0, 0, 0, 0);
        run_xfer(4'd8, 4'd1, 1, 0, 0, 1, 0);
        run_xfer(4'd11, 4'd5, 0, 0, 0, 0, 1);
        run_xfer(4'd12, 4'd3, 0, 1, 0, 1, 1);
        run_xfer(4'd13, 4'd0, 0, 2, 0, 1, 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule